// File: doc/BRIEF.md
# Interlaced Video Master Sync Generator

This block produces the horizontal and vertical synchronisation for interlaced standard-definition video. It counts the byte clock of a multiplexed 4:2:2 byte stream (Cb, Y, Cr, Y) and outputs the raster position. It runs either the 525-line or the 625-line raster. Each line is a fixed number of byte clocks: 1716 for 525 lines and 1728 for 625 lines by default.

The parity of each new field is carried by the relative timing of the two sync edges. At the start of an odd field the vertical sync falls together with the horizontal sync. At the start of an even field the vertical sync falls at the middle of a line, while horizontal sync is high.

The block also reports four other things: the current line number, whether the field is odd or even, and a field-sequence index. The index counts through 4 fields for 525 lines and 8 fields for 625 lines, so colour-framing logic downstream can align to it. The fourth is a vertical-blanking flag, which a disable input can suppress.

Top module: `video_sync_master`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block returns to line 1, byte 0. There `line_num` = 1, `field_seq` = 0, `field_odd` = 1 and `hsync_n` = 0. The raster standard is loaded from `std_625`.
- R2: A line lasts LINE_BYTES_525 byte clocks (`std_625` = 0) or LINE_BYTES_625 byte clocks (`std_625` = 1). `line_num` counts from 1 to 525 or 625, advances at the end of each line, and wraps to 1.
- R3: `hsync_n` is low for 2*HSYNC_PIX byte clocks, starting at byte 0 of every line. Byte 0 is a Cb slot: the byte index modulo 4 is 0.
- R4: The odd-field vertical sync pulse starts at line 1, byte 0, together with the fall of `hsync_n`. `vsync_n` stays low for lines 1 to 3 in 525 mode, and for lines 1, 2 and the first half of line 3 in 625 mode.
- R5: The even-field vertical sync pulse starts at the half-line byte (line length / 2), while `hsync_n` is high. In 525 mode this is on line 263, and the pulse lasts 3 lines, up to half of line 266. In 625 mode this is on line 313, and the pulse lasts 2.5 lines, up to the start of line 316.
- R6: `field_odd` is 1 on lines 1 to 262 (525 mode) or 1 to 312 (625 mode), and 0 on the remaining lines.
- R7: `field_seq` advances by one on the first byte of every field. It wraps modulo 4 in 525 mode and modulo 8 in 625 mode.
- R8: With `vbi_off` = 0, `vblank` is 1 on lines 1–21, 262–284 and 525 in 525 mode, and on lines 1–22, 311–335 and 624–625 in 625 mode. It is 0 on all other lines.
- R9: With `vbi_off` = 1, `vblank` is 0 on every line, and the input acts in the same cycle.
- R10: A change of `std_625` is taken only at the end of the last line of a frame. A change in the middle of a frame leaves the line count and line length untouched. When a change is taken, `field_seq` restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (27 MHz in use) |
| rst_n | input | 1 | Synchronous active-low reset |
| std_625 | input | 1 | Raster standard: 0 = 525 lines, 1 = 625 lines |
| vbi_off | input | 1 | 1 suppresses vertical-interval blanking |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_num | output | 10 | Current line, 1-based |
| field_odd | output | 1 | 1 during the odd field |
| field_seq | output | 3 | Field index within the 4- or 8-field sequence |
| vblank | output | 1 | Vertical-interval blanking flag |

## Verification
A table of raster points is walked for both standards:
- Points either side of every sync edge separate a pulse that is one byte too long or too short from a correct one.
- Points on the first and last line of each blanking range catch off-by-one range limits.
- Points at the half-line separate the even-field vertical sync from the odd-field one.

Separate runs follow `field_seq` across a full 4-field and a full 8-field sequence, which exposes a wrong modulus. A run also changes the standard in the middle of a frame: the old line length must persist to the frame end, and the index must restart. Toggling the blanking-disable input on a blanked line shows that it overrides the range decode.

// File: rtl/vsg_pkg.sv
// Package: shared types and raster constants for the master sync generator.
// Assumes line numbers are 1-based and fit in 10 bits.
package vsg_pkg;
    typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} std_e;
    typedef logic [9:0] line_t;

    localparam line_t LAST_525     = 10'd525;
    localparam line_t LAST_625     = 10'd625;
    localparam line_t ODD_END_525  = 10'd262;
    localparam line_t ODD_END_625  = 10'd312;
endpackage

// File: rtl/vsg_raster.sv
// Raster counter: byte position within a line and 1-based line number.
// The raster standard is loaded in reset and at frame end only, so a
// frame always completes with the line count and length it began with.
module vsg_raster
    import vsg_pkg::*;
#(
    parameter int L525 = 1716,
    parameter int L625 = 1728,
    localparam int LMAX = (L625 > L525) ? L625 : L525,
    localparam int HW   = $clog2(LMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_sel_i,
    output logic [HW-1:0] hpos_o,
    output line_t         line_o,
    output std_e          std_o,
    output logic          line_end_o,
    output logic          frame_end_o,
    output logic          std_chg_o
);
    localparam logic [HW-1:0] HLAST_525 = HW'(L525 - 1);
    localparam logic [HW-1:0] HLAST_625 = HW'(L625 - 1);

    logic [HW-1:0] hpos_q;
    line_t         line_q;
    std_e          std_q;

    // Decode the end of the line and of the frame for the current standard.
    always_comb begin
        line_end_o  = (hpos_q == ((std_q == STD_625) ? HLAST_625 : HLAST_525));
        frame_end_o = line_end_o && (line_q == ((std_q == STD_625) ? LAST_625 : LAST_525));
        std_chg_o   = frame_end_o && (std_e'(std_sel_i) != std_q);
    end

    // Advance byte and line counters; reload the standard at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos_q <= '0;
            line_q <= 10'd1;
            std_q  <= std_e'(std_sel_i);
        end else if (line_end_o) begin
            hpos_q <= '0;
            if (frame_end_o) begin
                line_q <= 10'd1;
                std_q  <= std_e'(std_sel_i);
            end else begin
                line_q <= line_q + 10'd1;
            end
        end else begin
            hpos_q <= hpos_q + 1'b1;
        end
    end

    assign hpos_o = hpos_q;
    assign line_o = line_q;
    assign std_o  = std_q;

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (line_q == 10'd1) && (hpos_q == '0));

    // R10
    std_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_q) |-> (line_q == 10'd1) && (hpos_q == '0));
endmodule

// File: rtl/vsg_sync_dec.sv
// Sync decoder: derives HSYNC, VSYNC and field parity from the raster.
// Assumes 2*HSYNC_PIX is below half a line, so the even-field VSYNC edge
// always falls while HSYNC is high.
module vsg_sync_dec
    import vsg_pkg::*;
#(
    parameter int L525      = 1716,
    parameter int L625      = 1728,
    parameter int HSYNC_PIX = 64,
    localparam int LMAX = (L625 > L525) ? L625 : L525,
    localparam int HW   = $clog2(LMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos_i,
    input  line_t         line_i,
    input  std_e          std_i,
    output logic          hsync_n_o,
    output logic          vsync_n_o,
    output logic          field_odd_o
);
    localparam logic [HW-1:0] HS_LEN   = HW'(2 * HSYNC_PIX);
    localparam logic [HW-1:0] HALF_525 = HW'(L525 / 2);
    localparam logic [HW-1:0] HALF_625 = HW'(L625 / 2);

    logic first_half;
    logic vs_act;

    // Decode the sync pulses for the active standard.
    always_comb begin
        hsync_n_o = (hpos_i >= HS_LEN);
        vs_act    = 1'b0;
        if (std_i == STD_625) begin
            first_half  = (hpos_i < HALF_625);
            field_odd_o = (line_i <= ODD_END_625);
            if ((line_i == 10'd1) || (line_i == 10'd2) || ((line_i == 10'd3) && first_half))
                vs_act = 1'b1;
            if (((line_i == 10'd313) && !first_half) || (line_i == 10'd314) || (line_i == 10'd315))
                vs_act = 1'b1;
        end else begin
            first_half  = (hpos_i < HALF_525);
            field_odd_o = (line_i <= ODD_END_525);
            if ((line_i >= 10'd1) && (line_i <= 10'd3))
                vs_act = 1'b1;
            if (((line_i == 10'd263) && !first_half) || (line_i == 10'd264) ||
                (line_i == 10'd265) || ((line_i == 10'd266) && first_half))
                vs_act = 1'b1;
        end
        vsync_n_o = !vs_act;
    end

    // R3
    hsync_cb_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n_o) |-> (hpos_i[1:0] == 2'b00));

    // R4
    odd_vs_with_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n_o) && field_odd_o) |-> (!hsync_n_o && (line_i == 10'd1)));

    // R5
    even_vs_hs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n_o) && !field_odd_o) |-> hsync_n_o);
endmodule

// File: rtl/vsg_vblank.sv
// Vertical blanking decoder: flags the vertical-interval lines per standard.
// Assumes the disable input may change at any time; it acts combinationally.
module vsg_vblank
    import vsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line_i,
    input  std_e  std_i,
    input  logic  vbi_off_i,
    output logic  vblank_o
);
    logic in_range;

    // Match the line against the three blanking ranges of the standard.
    always_comb begin
        if (std_i == STD_625)
            in_range = (line_i <= 10'd22) ||
                       ((line_i >= 10'd311) && (line_i <= 10'd335)) ||
                       (line_i >= 10'd624);
        else
            in_range = (line_i <= 10'd21) ||
                       ((line_i >= 10'd262) && (line_i <= 10'd284)) ||
                       (line_i == LAST_525);
        vblank_o = in_range && !vbi_off_i;
    end

    // R9
    vbi_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_off_i |-> !vblank_o);

    // R8
    active_area_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_i >= 10'd40) && (line_i <= 10'd250)) |-> !vblank_o);
endmodule

// File: rtl/vsg_field_seq.sv
// Field sequence counter: advances on the first byte of each field and
// wraps at 4 (525) or 8 (625). Restarts at 0 when the standard changes.
module vsg_field_seq
    import vsg_pkg::*;
#(
    parameter int HW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos_i,
    input  line_t         line_i,
    input  std_e          std_i,
    input  logic          line_end_i,
    input  logic          frame_end_i,
    input  logic          std_chg_i,
    output logic [2:0]    seq_o
);
    logic       field_end;
    logic [2:0] wrap_mask;

    // Detect the last byte of a field and pick the wrap mask.
    always_comb begin
        field_end = frame_end_i ||
                    (line_end_i && (line_i == ((std_i == STD_625) ? ODD_END_625 : ODD_END_525)));
        wrap_mask = (std_i == STD_625) ? 3'b111 : 3'b011;
    end

    // Step the index at each field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_o <= 3'd0;
        else if (std_chg_i)
            seq_o <= 3'd0;
        else if (field_end)
            seq_o <= (seq_o + 3'd1) & wrap_mask;
    end

    // R7
    seq_at_field_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_o) |-> (hpos_i == '0));

    // R7
    seq_range_525_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (std_i == STD_525) |-> (seq_o[2] == 1'b0));
endmodule

// File: rtl/video_sync_master.sv
// Top: interlaced master sync generator for 525/625-line rasters.
// Assumes one clock per multiplexed 4:2:2 byte; all outputs are decoded
// from registered raster state, and vblank also from the vbi_off input.
module video_sync_master
    import vsg_pkg::*;
#(
    parameter int LINE_BYTES_525 = 1716,
    parameter int LINE_BYTES_625 = 1728,
    parameter int HSYNC_PIX      = 64,
    localparam int LMAX = (LINE_BYTES_625 > LINE_BYTES_525) ? LINE_BYTES_625 : LINE_BYTES_525,
    localparam int HW   = $clog2(LMAX)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std_625,
    input  logic       vbi_off,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [9:0] line_num,
    output logic       field_odd,
    output logic [2:0] field_seq,
    output logic       vblank
);
    logic [HW-1:0] hpos;
    line_t         line;
    std_e          std_cur;
    logic          line_end;
    logic          frame_end;
    logic          std_chg;

    vsg_raster #(.L525(LINE_BYTES_525), .L625(LINE_BYTES_625)) u_raster (
        .clk(clk), .rst_n(rst_n), .std_sel_i(std_625),
        .hpos_o(hpos), .line_o(line), .std_o(std_cur),
        .line_end_o(line_end), .frame_end_o(frame_end), .std_chg_o(std_chg)
    );

    vsg_sync_dec #(.L525(LINE_BYTES_525), .L625(LINE_BYTES_625), .HSYNC_PIX(HSYNC_PIX)) u_sync (
        .clk(clk), .rst_n(rst_n), .hpos_i(hpos), .line_i(line), .std_i(std_cur),
        .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .field_odd_o(field_odd)
    );

    vsg_vblank u_vblank (
        .clk(clk), .rst_n(rst_n), .line_i(line), .std_i(std_cur),
        .vbi_off_i(vbi_off), .vblank_o(vblank)
    );

    vsg_field_seq #(.HW(HW)) u_seq (
        .clk(clk), .rst_n(rst_n), .hpos_i(hpos), .line_i(line), .std_i(std_cur),
        .line_end_i(line_end), .frame_end_i(frame_end), .std_chg_i(std_chg),
        .seq_o(field_seq)
    );

    assign line_num = line;
endmodule

// File: tb/sim_video_sync_master.sv
`timescale 1ns/1ps
module sim_video_sync_master;
    localparam int BL525 = 24;
    localparam int BL625 = 28;
    localparam int BHP   = 4;
    localparam int NV    = 35;

    // entry: [31] std, [30:21] line, [20:10] byte, [3] hs_n, [2] vs_n, [1] odd, [0] vblank
    function automatic logic [31:0] mk(input int s, input int ln, input int h,
                                       input int hs, input int vs, input int od, input int vb);
        mk = {s[0], ln[9:0], h[10:0], 6'd0, hs[0], vs[0], od[0], vb[0]};
    endfunction

    localparam logic [31:0] VEC [NV] = '{
        mk(0,1,0,0,0,1,1),    mk(0,1,8,1,0,1,1),    mk(0,2,7,0,0,1,1),
        mk(0,3,23,1,0,1,1),   mk(0,4,0,0,1,1,1),    mk(0,21,5,0,1,1,1),
        mk(0,22,0,0,1,1,0),   mk(0,261,23,1,1,1,0), mk(0,262,0,0,1,1,1),
        mk(0,262,23,1,1,1,1), mk(0,263,11,1,1,0,1), mk(0,263,12,1,0,0,1),
        mk(0,266,11,1,0,0,1), mk(0,266,12,1,1,0,1), mk(0,284,20,1,1,0,1),
        mk(0,285,0,0,1,0,0),  mk(0,524,10,1,1,0,0), mk(0,525,3,0,1,0,1),
        mk(1,1,0,0,0,1,1),    mk(1,3,13,1,0,1,1),   mk(1,3,14,1,1,1,1),
        mk(1,22,27,1,1,1,1),  mk(1,23,0,0,1,1,0),   mk(1,310,0,0,1,1,0),
        mk(1,311,0,0,1,1,1),  mk(1,312,27,1,1,1,1), mk(1,313,13,1,1,0,1),
        mk(1,313,14,1,0,0,1), mk(1,315,27,1,0,0,1), mk(1,316,0,0,1,0,1),
        mk(1,335,27,1,1,0,1), mk(1,336,0,0,1,0,0),  mk(1,623,0,0,1,0,0),
        mk(1,624,0,0,1,0,1),  mk(1,625,27,1,1,0,1)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_625 = 1'b0;
    logic       vbi_off = 1'b0;
    logic       hsync_n, vsync_n, field_odd, vblank;
    logic [9:0] line_num;
    logic [2:0] field_seq;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;

    video_sync_master #(.LINE_BYTES_525(BL525), .LINE_BYTES_625(BL625), .HSYNC_PIX(BHP)) u0 (
        .clk(clk), .rst_n(rst_n), .std_625(std_625), .vbi_off(vbi_off),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .line_num(line_num),
        .field_odd(field_odd), .field_seq(field_seq), .vblank(vblank)
    );

    always #2.5 clk = ~clk;

    // byte clocks since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", what, cyc, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0;
        std_625 = s;
        vbi_off = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic goto_cyc(input int t);
        while (cyc != t) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cur_std;
        cur_std = 2;
        // Table walk over both standards: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            int s, ln, h, len, tgt;
            s   = int'(VEC[i][31]);
            ln  = int'(VEC[i][30:21]);
            h   = int'(VEC[i][20:10]);
            len = (s == 1) ? BL625 : BL525;
            tgt = (ln - 1) * len + h;
            if (s != cur_std || tgt < cyc) begin
                do_reset(s[0]);
                cur_std = s;
            end
            goto_cyc(tgt);
            chk("R2 line_num", int'(line_num), ln);
            chk("R3 hsync_n", int'(hsync_n), int'(VEC[i][3]));
            chk("R4,R5 vsync_n", int'(vsync_n), int'(VEC[i][2]));
            chk("R6 field_odd", int'(field_odd), int'(VEC[i][1]));
            chk("R8 vblank", int'(vblank), int'(VEC[i][0]));
        end

        // R7: 525 sequence of four fields
        do_reset(1'b0);
        chk("R7 seq start 525", int'(field_seq), 0);
        goto_cyc(262 * BL525 - 1);
        chk("R7 seq before even 525", int'(field_seq), 0);
        goto_cyc(262 * BL525);
        chk("R7 seq even 525", int'(field_seq), 1);
        goto_cyc(525 * BL525);
        chk("R7 seq field3 525", int'(field_seq), 2);
        goto_cyc(525 * BL525 + 262 * BL525);
        chk("R7 seq field4 525", int'(field_seq), 3);
        goto_cyc(1050 * BL525);
        chk("R7 seq wrap 525", int'(field_seq), 0);

        // R7: 625 sequence of eight fields
        do_reset(1'b1);
        for (int f = 1; f <= 8; f++) begin
            int t;
            t = ((f / 2) * 625 + ((f % 2) ? 312 : 0)) * BL625;
            goto_cyc(t);
            chk("R7 seq 625", int'(field_seq), f % 8);
        end

        // R9: disable overrides blanking on a blanked line
        do_reset(1'b0);
        goto_cyc(9 * BL525 + 5);
        chk("R9 vblank before disable", int'(vblank), 1);
        vbi_off = 1'b1;
        #0.5;
        chk("R9 vblank disabled", int'(vblank), 0);
        goto_cyc(270 * BL525);
        chk("R9 vblank disabled line 271", int'(vblank), 0);
        vbi_off = 1'b0;
        #0.5;
        chk("R9 vblank re-enabled", int'(vblank), 1);

        // R10: mid-frame change waits for frame end, then index restarts
        do_reset(1'b0);
        goto_cyc(99 * BL525);
        std_625 = 1'b1;
        goto_cyc(525 * BL525 - 1);
        chk("R10 old line count kept", int'(line_num), 525);
        chk("R10 old blanking kept", int'(vblank), 1);
        goto_cyc(525 * BL525);
        chk("R10 new frame line", int'(line_num), 1);
        chk("R10 seq restarts", int'(field_seq), 0);
        goto_cyc(525 * BL525 + BL525);
        chk("R10 new length in force", int'(line_num), 1);
        goto_cyc(525 * BL525 + BL625);
        chk("R10 new length line 2", int'(line_num), 2);
        goto_cyc(525 * BL525 + 623 * BL625);
        chk("R10 625 lines reached", int'(line_num), 624);

        // R1: reset from mid-raster
        goto_cyc(525 * BL525 + 623 * BL625 + 20);
        rst_n = 1'b0;
        std_625 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 line_num", int'(line_num), 1);
        chk("R1 field_seq", int'(field_seq), 0);
        chk("R1 field_odd", int'(field_odd), 1);
        chk("R1 hsync_n", int'(hsync_n), 0);
        rst_n = 1'b1;
        goto_cyc(BL525 - 1);
        chk("R1 standard reloaded", int'(line_num), 1);
        goto_cyc(BL525);
        chk("R1 525 length after reset", int'(line_num), 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule